// File: doc/BRIEF.md
# Two-Way Instruction Cache Controller

This block is a small set-associative instruction cache placed between an instruction fetch unit and a 64-bit memory port. Each request carries a virtual address, a physical address and an operation code. A fetch returns one 32-bit instruction. A fetch normally looks up the cache by the physical address, using two ways per set and one least-recently-used bit per set. A three-bit coherency attribute in the top physical address bits can select an uncached path instead. That path makes a single 4-byte memory read and does not touch the cache arrays. On a miss the controller fills a whole line with consecutive 8-byte reads.

Three maintenance operations act on the set and way picked by the virtual address: an unconditional invalidate, an invalidate that applies only on a tag match, and a line fill. Operations aimed at a second-level cache, and unknown codes, make no change to the cache. Every operation, recognised or not, clears a two-entry recent-line record. Cached fetches load that record in round-robin order.

The controller is built around one state machine. Its states are ST_CLEAR, ST_IDLE, ST_LOOKUP, ST_UNC_REQ, ST_UNC_WAIT, ST_FILL_REQ, ST_FILL_WAIT, ST_RESP and ST_MAINT.
- After reset, ST_CLEAR sweeps every set and then moves to ST_IDLE.
- ST_IDLE routes an accepted request as follows: an uncached fetch goes to ST_UNC_REQ, a cached fetch to ST_LOOKUP, the fill operation to ST_FILL_REQ, and every other code to ST_MAINT.
- ST_LOOKUP moves to ST_RESP on a hit and to ST_FILL_REQ on a miss.
- ST_FILL_REQ and ST_FILL_WAIT alternate once per beat. After the last beat the machine moves to ST_RESP for a fetch, or to ST_MAINT for the fill operation.
- ST_UNC_REQ moves to ST_UNC_WAIT, which moves to ST_RESP when the read data returns.
- ST_RESP and ST_MAINT both return to ST_IDLE.

Top module: `icache_ctrl`

## Requirements
- R1: After reset the block holds busy high for exactly SETS cycles while it marks every tag invalid and clears every LRU bit. Both recent-line entries are invalid during and after this sweep, and every later first fetch of a line misses.
- R2: A fetch whose physical address bits [31:29] equal 5 issues exactly one memory read with mem_dw=0 at the unmodified physical address. It returns mem_rdata[31:0] as the instruction and leaves the tags, the LRU bits and the recent-line record unchanged.
- R3: A cached fetch takes its tag from physical bits [28:12] and its set from bits [11:5]. On a hit it returns the instruction with no memory request.
- R4: A cached miss fills the least-recently-used way of the set with four reads, each with mem_dw=1. The reads go to the line base plus 0, 8, 16 and 24, in that order, and the new tag is stored.
- R5: Each cached fetch, hit or fill, makes the accessed way most recently used. The next miss in that set therefore evicts the other way.
- R6: The returned instruction comes from the doubleword at physical bits [4:3]. Bits [63:32] are returned when virtual bit 2 is 1, and bits [31:0] when it is 0.
- R7: Each cached fetch writes physical bits [31:5] into the recent-line entry marked least recent and sets that entry valid. Entry 0 is used first after reset, and the mark then toggles. The tags are exposed as lbuf_tags[26:0] for entry 0 and lbuf_tags[53:27] for entry 1.
- R8: Operation code 1 invalidates, without condition, the way chosen by virtual bit 12 in the set chosen by virtual bits [11:5].
- R9: Operation code 2 invalidates the way chosen by the same virtual bits only when its stored tag equals physical bits [28:12]. Otherwise it has no effect.
- R10: Operation code 3 reloads the way chosen by the virtual address with four 8-byte reads from the line-aligned physical address and stores the new tag. It does not change the LRU bit.
- R11: Operation codes 4 to 7 change no tag and issue no memory read. Every operation with a code from 1 to 7 leaves both recent-line entries invalid when it completes, and no operation returns a response.
- R12: busy is high from the cycle after a request is accepted until the cycle after its response or completion. Requests presented while busy is high are dropped. mem_req is a single-cycle pulse, with at most one read outstanding, and rsp_valid lasts one cycle.
- R13: A real tag of all ones (physical bits [28:12] all set) is cached and hits like any other tag. It is never mistaken for the invalid marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_op | input | 3 | 0 fetch, 1 index invalidate, 2 hit invalidate, 3 fill, 4-7 ignored |
| req_va | input | VA_W | Virtual address |
| req_pa | input | PA_W | Physical address with coherency attribute in the top 3 bits |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Instruction valid, one cycle |
| rsp_instr | output | 32 | Fetched instruction |
| mem_req | output | 1 | Memory read request pulse |
| mem_dw | output | 1 | 1: 8-byte read, 0: 4-byte read |
| mem_addr | output | PA_W | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| lbuf_valid | output | 2 | Recent-line entry valid bits |
| lbuf_tags | output | 2*(PA_W-5) | Recent-line tags, entry 0 in the low half |

## Verification
A corrupted tag or LRU bit does not show on the data path at once. It shows as a memory request count that differs from the expected hit or miss pattern, at the next fetch to that set. The directed sequences therefore count mem_req pulses after every fetch, and they replay sets whose victim choice depends on the fetch history, so a wrong LRU bit appears within one or two fetches. A wrong recent-line pointer or a missed flush is visible on lbuf_valid and lbuf_tags as soon as the request completes, and it is compared against a model after every request.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int WAYS   = 2;
    localparam int ATTR_W = 3;

    localparam logic [2:0] OP_FETCH   = 3'd0;
    localparam logic [2:0] OP_IDX_INV = 3'd1;
    localparam logic [2:0] OP_HIT_INV = 3'd2;
    localparam logic [2:0] OP_FILL    = 3'd3;

    localparam logic [ATTR_W-1:0] ATTR_UNCACHED = 3'd5;

    typedef enum logic [3:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOKUP,
        ST_UNC_REQ,
        ST_UNC_WAIT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_RESP,
        ST_MAINT
    } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
    import icache_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 17
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] acc_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             clr_en,
    input  logic             tag_we,
    input  logic             tag_way,
    input  logic             tag_inval,
    input  logic             lru_we,
    input  logic             lru_way,
    output logic [WAYS-1:0]  hit_vec,
    output logic             victim
);
    // Stored tags carry a leading zero, so a real tag can never equal the all-ones marker.
    localparam int SW = TAG_W + 1;

    logic [SW-1:0]   tags_q [SETS][WAYS];
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (clr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                tags_q[acc_set][w] <= '1;
            end
            lru_q[acc_set] <= 1'b0;
        end else begin
            if (tag_we) begin
                tags_q[acc_set][tag_way] <= tag_inval ? '1 : {1'b0, lk_tag};
            end
            if (lru_we) begin
                lru_q[acc_set] <= ~lru_way;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = (tags_q[acc_set][w] == {1'b0, lk_tag});
    end

    assign victim = lru_q[acc_set];
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int SETS   = 128,
    parameter int IDX_W  = 7,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  set,
    input  logic              way,
    input  logic [BEAT_W-1:0] wbeat,
    input  logic [BEAT_W-1:0] rbeat,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata
);
    localparam int AW    = IDX_W + 1 + BEAT_W;
    localparam int DEPTH = 1 << AW;

    logic [63:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[{set, way, wbeat}] <= wdata;
        end
    end

    assign rdata = mem_q[{set, way, rbeat}];
endmodule

// File: rtl/icache_line_buf.sv
module icache_line_buf #(
    parameter int LTAG_W = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [LTAG_W-1:0]   push_tag,
    input  logic                flush,
    output logic [1:0]          valid,
    output logic [2*LTAG_W-1:0] tags
);
    logic [LTAG_W-1:0] tag_q [2];
    logic              ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid    <= 2'b00;
            ptr_q    <= 1'b0;
            tag_q[0] <= '0;
            tag_q[1] <= '0;
        end else if (flush) begin
            valid <= 2'b00;
        end else if (push) begin
            valid[ptr_q] <= 1'b1;
            tag_q[ptr_q] <= push_tag;
            ptr_q        <= ~ptr_q;
        end
    end

    for (genvar e = 0; e < 2; e++) begin : g_out
        assign tags[e*LTAG_W +: LTAG_W] = tag_q[e];
    end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int VA_W       = 32,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2:0]              req_op,
    input  logic [VA_W-1:0]         req_va,
    input  logic [PA_W-1:0]         req_pa,
    output logic                    busy,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_instr,
    output logic                    mem_req,
    output logic                    mem_dw,
    output logic [PA_W-1:0]         mem_addr,
    input  logic                    mem_rvalid,
    input  logic [63:0]             mem_rdata,
    output logic [1:0]              lbuf_valid,
    output logic [2*(PA_W-$clog2(LINE_BYTES))-1:0] lbuf_tags
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int BEATS   = LINE_BYTES / 8;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int TAG_W   = PA_W - ATTR_W - IDX_W - OFF_W;
    localparam int LTAG_W  = PA_W - OFF_W;
    localparam int WAY_BIT = OFF_W + IDX_W;

    ic_state_e st_q, st_d;

    logic [2:0]        op_q;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   pa_q;
    logic              way_q;
    logic [BEAT_W-1:0] beat_q;
    logic [IDX_W-1:0]  clr_q;
    logic [31:0]       unc_q;

    logic [IDX_W-1:0]  acc_set;
    logic [TAG_W-1:0]  pa_tag;
    logic [WAYS-1:0]   hit_vec;
    logic              hit, hit_way, victim;
    logic              uncached_q;
    logic [63:0]       rd_dw;

    logic clr_en, tag_we, tag_inval, lru_we, data_we, lb_push, lb_flush;

    assign pa_tag     = pa_q[PA_W-ATTR_W-1 : OFF_W+IDX_W];
    assign uncached_q = (pa_q[PA_W-1 -: ATTR_W] == ATTR_UNCACHED);
    assign hit        = |hit_vec;
    assign hit_way    = hit_vec[1];
    assign acc_set    = (st_q == ST_CLEAR)   ? clr_q :
                        (op_q == OP_FETCH)   ? pa_q[OFF_W +: IDX_W] :
                                               va_q[OFF_W +: IDX_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAR;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR:     if (clr_q == IDX_W'(SETS - 1)) st_d = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_op == OP_FETCH) begin
                        st_d = (req_pa[PA_W-1 -: ATTR_W] == ATTR_UNCACHED) ? ST_UNC_REQ : ST_LOOKUP;
                    end else if (req_op == OP_FILL) begin
                        st_d = ST_FILL_REQ;
                    end else begin
                        st_d = ST_MAINT;
                    end
                end
            end
            ST_LOOKUP:    st_d = hit ? ST_RESP : ST_FILL_REQ;
            ST_UNC_REQ:   st_d = ST_UNC_WAIT;
            ST_UNC_WAIT:  if (mem_rvalid) st_d = ST_RESP;
            ST_FILL_REQ:  st_d = ST_FILL_WAIT;
            ST_FILL_WAIT: begin
                if (mem_rvalid) begin
                    if (beat_q == BEAT_W'(BEATS - 1)) begin
                        st_d = (op_q == OP_FETCH) ? ST_RESP : ST_MAINT;
                    end else begin
                        st_d = ST_FILL_REQ;
                    end
                end
            end
            ST_RESP:      st_d = ST_IDLE;
            ST_MAINT:     st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_req   = 1'b0;
        mem_dw    = 1'b0;
        mem_addr  = '0;
        rsp_valid = 1'b0;
        clr_en    = 1'b0;
        tag_we    = 1'b0;
        tag_inval = 1'b0;
        lru_we    = 1'b0;
        data_we   = 1'b0;
        lb_push   = 1'b0;
        lb_flush  = 1'b0;
        unique case (st_q)
            ST_CLEAR:    clr_en = 1'b1;
            ST_UNC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = pa_q;
            end
            ST_FILL_REQ: begin
                mem_req  = 1'b1;
                mem_dw   = 1'b1;
                mem_addr = {pa_q[PA_W-1:OFF_W], beat_q, 3'b000};
            end
            ST_FILL_WAIT: begin
                if (mem_rvalid) begin
                    data_we = 1'b1;
                    tag_we  = (beat_q == BEAT_W'(BEATS - 1));
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                lru_we    = !uncached_q;
                lb_push   = !uncached_q;
            end
            ST_MAINT: begin
                lb_flush  = 1'b1;
                tag_inval = 1'b1;
                if (op_q == OP_IDX_INV) tag_we = 1'b1;
                if (op_q == OP_HIT_INV) tag_we = hit_vec[way_q];
            end
            default: ;
        endcase
    end

    // Request and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_FETCH;
            va_q   <= '0;
            pa_q   <= '0;
            way_q  <= 1'b0;
            beat_q <= '0;
            clr_q  <= '0;
            unc_q  <= '0;
        end else begin
            unique case (st_q)
                ST_CLEAR: clr_q <= clr_q + 1'b1;
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= req_op;
                        va_q   <= req_va;
                        pa_q   <= req_pa;
                        way_q  <= req_va[WAY_BIT];
                        beat_q <= '0;
                    end
                end
                ST_LOOKUP:    way_q <= hit ? hit_way : victim;
                ST_UNC_WAIT:  if (mem_rvalid) unc_q <= mem_rdata[31:0];
                ST_FILL_WAIT: if (mem_rvalid) beat_q <= beat_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign rsp_instr = uncached_q ? unc_q : (va_q[2] ? rd_dw[63:32] : rd_dw[31:0]);

    icache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .acc_set   (acc_set),
        .lk_tag    (pa_tag),
        .clr_en    (clr_en),
        .tag_we    (tag_we),
        .tag_way   (way_q),
        .tag_inval (tag_inval),
        .lru_we    (lru_we),
        .lru_way   (way_q),
        .hit_vec   (hit_vec),
        .victim    (victim)
    );

    icache_data_store #(.SETS(SETS), .IDX_W(IDX_W), .BEAT_W(BEAT_W)) data_i (
        .clk   (clk),
        .we    (data_we),
        .set   (acc_set),
        .way   (way_q),
        .wbeat (beat_q),
        .rbeat (pa_q[3 +: BEAT_W]),
        .wdata (mem_rdata),
        .rdata (rd_dw)
    );

    icache_line_buf #(.LTAG_W(LTAG_W)) lbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (lb_push),
        .push_tag (pa_q[PA_W-1:OFF_W]),
        .flush    (lb_flush),
        .valid    (lbuf_valid),
        .tags     (lbuf_tags)
    );
endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk
    import icache_pkg::*;
#(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            rsp_valid,
    input logic            mem_req,
    input logic            mem_dw,
    input logic [PA_W-1:0] mem_addr,
    input logic [1:0]      lbuf_valid,
    input ic_state_e       st_q
);
    a_r12_mem_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r12_mem_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r12_rsp_then_free: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy && !rsp_valid);

    a_r2_uncached_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_dw) |-> (mem_addr[PA_W-1 -: 3] == 3'd5));

    a_r4_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_dw) |-> (mem_addr[2:0] == 3'b000));

    a_r11_flush_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MAINT) |=> (lbuf_valid == 2'b00));

    a_r1_clear_lbuf_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLEAR) |-> (lbuf_valid == 2'b00));
endmodule

bind icache_ctrl icache_ctrl_chk #(.PA_W(PA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .mem_req    (mem_req),
    .mem_dw     (mem_dw),
    .mem_addr   (mem_addr),
    .lbuf_valid (lbuf_valid),
    .st_q       (st_q)
);

// File: tb/icache_ctrl_tb.sv
module icache_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETS       = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_va = '0;
    logic [31:0] req_pa = '0;
    logic        busy, rsp_valid, mem_req, mem_dw;
    logic [31:0] rsp_instr, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [1:0]  lbuf_valid;
    logic [53:0] lbuf_tags;

    int checks = 0, fails = 0;
    int n_mem = 0, n_rsp = 0;
    logic [31:0] rsp_last;
    logic [31:0] log_addr [8];
    logic        log_dw [8];
    bit done = 0;

    logic [1:0]  m_v = 2'b00;
    logic [26:0] m_tag [2];
    bit          m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_va(req_va), .req_pa(req_pa), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_instr(rsp_instr), .mem_req(mem_req), .mem_dw(mem_dw),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .lbuf_valid(lbuf_valid), .lbuf_tags(lbuf_tags)
    );

    // Memory model: answers each request one cycle later
    initial begin
        bit          pend = 0;
        logic [31:0] pa_a;
        logic        pa_d;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                mem_rvalid = 1'b1;
                if (pa_d) mem_rdata = {~{pa_a[31:3], 3'b000}, {pa_a[31:3], 3'b000}};
                else      mem_rdata = {32'h0, pa_a ^ 32'h5A5A_5A5A};
                pend = 0;
            end
            if (mem_req) begin
                if (n_mem < 8) begin
                    log_addr[n_mem] = mem_addr;
                    log_dw[n_mem]   = mem_dw;
                end
                n_mem++;
                pend = 1;
                pa_a = mem_addr;
                pa_d = mem_dw;
            end
        end
    end

    // Response monitor
    initial forever begin
        @(negedge clk);
        if (rsp_valid) begin
            n_rsp++;
            rsp_last = rsp_instr;
        end
    end

    task automatic check(input bit ok, input string r, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pa(input logic [2:0] at, input logic [16:0] tg,
                                          input logic [6:0] ix, input logic [4:0] of);
        return {at, tg, ix, of};
    endfunction

    function automatic logic [31:0] mk_va(input logic w, input logic [6:0] s);
        return {19'h0, w, s, 5'h0};
    endfunction

    function automatic logic [31:0] exp_cached(input logic [31:0] pa);
        logic [31:0] a8;
        a8 = {pa[31:3], 3'b000};
        return pa[2] ? ~a8 : a8;
    endfunction

    task automatic do_req(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa);
        @(negedge clk);
        n_mem = 0; n_rsp = 0;
        req_valid = 1'b1; req_op = op; req_va = va; req_pa = pa;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        if (op == 3'd0 && pa[31:29] != 3'd5) begin
            m_v[m_ptr]   = 1'b1;
            m_tag[m_ptr] = pa[31:5];
            m_ptr        = ~m_ptr;
        end else if (op != 3'd0) begin
            m_v = 2'b00;
        end
    endtask

    task automatic check_lbuf(input string r);
        check(lbuf_valid == m_v, r, "line buffer valid", 64'(lbuf_valid), 64'(m_v));
        check(lbuf_tags == {m_tag[1], m_tag[0]}, r, "line buffer tags",
              64'(lbuf_tags), 64'({m_tag[1], m_tag[0]}));
    endtask

    task automatic fetch_chk(input string r, input logic [31:0] pa, input int exp_mem);
        do_req(3'd0, pa, pa);
        check(n_rsp == 1, r, "one response", 64'(n_rsp), 64'd1);
        check(n_mem == exp_mem, r, "memory reads", 64'(n_mem), 64'(exp_mem));
        check(rsp_last == exp_cached(pa), r, "instruction", 64'(rsp_last), 64'(exp_cached(pa)));
        check_lbuf("R7");
    endtask

    task automatic t_reset();
        int n;
        m_tag[0] = '0; m_tag[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (busy) begin
            check(lbuf_valid == 2'b00, "R1", "lbuf empty during sweep", 64'(lbuf_valid), 64'd0);
            n++;
            @(negedge clk);
            if (n > 1000) break;
        end
        check(n == SETS, "R1", "sweep cycles", 64'(n), 64'(SETS));
        check(lbuf_valid == 2'b00 && rsp_valid == 1'b0, "R1", "idle outputs",
              64'({lbuf_valid, rsp_valid}), 64'd0);
    endtask

    task automatic t_miss_and_hit();
        logic [31:0] a;
        logic [31:0] base;
        a = mk_pa(3'd0, 17'h00A1, 7'd9, 5'h14);
        base = {a[31:5], 5'h0};
        fetch_chk("R4", a, 4);
        for (int k = 0; k < 4; k++) begin
            check(log_addr[k] == base + 32'(8 * k) && log_dw[k] == 1'b1, "R4", "fill beat address",
                  64'({log_dw[k], log_addr[k]}), 64'({1'b1, base + 32'(8 * k)}));
        end
        fetch_chk("R3", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h08), 0);
        fetch_chk("R6", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h1C), 0);
    endtask

    task automatic t_lru();
        // A sits in way 0; B, C compete for way 1 (R5)
        fetch_chk("R5", mk_pa(3'd0, 17'h00B2, 7'd9, 5'h00), 4);
        fetch_chk("R5", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h04), 0);
        fetch_chk("R5", mk_pa(3'd0, 17'h00C3, 7'd9, 5'h10), 4);
        fetch_chk("R5", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h00), 0);
        fetch_chk("R5", mk_pa(3'd0, 17'h00B2, 7'd9, 5'h18), 4);
        fetch_chk("R5", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h0C), 0);
    endtask

    task automatic t_uncached();
        logic [31:0] p;
        logic [53:0] tags_before;
        logic [1:0]  v_before;
        p = mk_pa(3'd5, 17'h00A1, 7'd9, 5'h04);
        tags_before = lbuf_tags; v_before = lbuf_valid;
        do_req(3'd0, p, p);
        check(n_mem == 1 && log_dw[0] == 1'b0 && log_addr[0] == p, "R2", "single word read",
              64'({n_mem[3:0], log_dw[0], log_addr[0]}), 64'({4'd1, 1'b0, p}));
        check(rsp_last == (p ^ 32'h5A5A_5A5A), "R2", "uncached instruction",
              64'(rsp_last), 64'(p ^ 32'h5A5A_5A5A));
        check(lbuf_tags == tags_before && lbuf_valid == v_before, "R2", "line buffer untouched",
              64'(lbuf_tags), 64'(tags_before));
        fetch_chk("R2", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h04), 0);
    endtask

    task automatic t_index_inv();
        do_req(3'd1, mk_va(1'b1, 7'd9), 32'h0);
        check(n_rsp == 0 && n_mem == 0, "R8", "op quiet", 64'({n_rsp, n_mem}), 64'd0);
        check_lbuf("R11");
        fetch_chk("R8", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h00), 0);
        fetch_chk("R8", mk_pa(3'd0, 17'h00B2, 7'd9, 5'h00), 4);
    endtask

    task automatic t_hit_inv();
        do_req(3'd2, mk_va(1'b0, 7'd9), mk_pa(3'd0, 17'h00B2, 7'd9, 5'h0));
        check_lbuf("R11");
        fetch_chk("R9", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h00), 0);
        do_req(3'd2, mk_va(1'b0, 7'd9), mk_pa(3'd0, 17'h00A1, 7'd9, 5'h0));
        fetch_chk("R9", mk_pa(3'd0, 17'h00A1, 7'd9, 5'h00), 4);
    endtask

    task automatic t_fill_op();
        logic [31:0] d;
        d = mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h00);
        do_req(3'd3, mk_va(1'b1, 7'd20), d);
        check(n_mem == 4 && n_rsp == 0, "R10", "fill reads, no response",
              64'({n_mem, n_rsp}), 64'({32'd4, 32'd0}));
        for (int k = 0; k < 4; k++) begin
            check(log_addr[k] == d + 32'(8 * k) && log_dw[k], "R10", "fill address",
                  64'(log_addr[k]), 64'(d + 32'(8 * k)));
        end
        check_lbuf("R11");
        fetch_chk("R10", mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h0C), 0);
        // LRU bit of set 20 still selects way 0, so this miss must not evict the filled way
        fetch_chk("R10", mk_pa(3'd0, 17'h0E0E, 7'd20, 5'h00), 4);
        fetch_chk("R10", mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h10), 0);
    endtask

    task automatic t_ignored();
        for (int op = 4; op < 8; op++) begin
            fetch_chk("R11", mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h00), 0);
            do_req(3'(op), mk_va(1'b1, 7'd20), mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h0));
            check(n_mem == 0 && n_rsp == 0, "R11", "ignored op quiet",
                  64'({n_mem, n_rsp}), 64'd0);
            check(lbuf_valid == 2'b00, "R11", "lbuf flushed", 64'(lbuf_valid), 64'd0);
        end
        fetch_chk("R11", mk_pa(3'd0, 17'h0D0D, 7'd20, 5'h00), 0);
    endtask

    task automatic t_all_ones_tag();
        fetch_chk("R13", mk_pa(3'd0, 17'h1FFFF, 7'd33, 5'h04), 4);
        fetch_chk("R13", mk_pa(3'd0, 17'h1FFFF, 7'd33, 5'h18), 0);
    endtask

    task automatic t_busy_drop();
        logic [31:0] g;
        bit stray;
        g = mk_pa(3'd0, 17'h0404, 7'd40, 5'h00);
        @(negedge clk);
        n_mem = 0; n_rsp = 0;
        req_valid = 1'b1; req_op = 3'd0; req_va = g; req_pa = g;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        req_valid = 1'b1; req_pa = mk_pa(3'd5, 17'h0, 7'd1, 5'h0); req_va = req_pa;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        stray = 0;
        repeat (6) begin
            if (busy) stray = 1;
            @(negedge clk);
        end
        m_v[m_ptr] = 1'b1; m_tag[m_ptr] = g[31:5]; m_ptr = ~m_ptr;
        check(n_rsp == 1 && n_mem == 4 && !stray, "R12", "request during busy dropped",
              64'({n_rsp, n_mem}), 64'({32'd1, 32'd4}));
        check(rsp_last == exp_cached(g), "R12", "instruction", 64'(rsp_last), 64'(exp_cached(g)));
        check_lbuf("R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_miss_and_hit();
        t_lru();
        t_uncached();
        t_index_inv();
        t_hit_inv();
        t_fill_op();
        t_ignored();
        t_all_ones_tag();
        t_busy_drop();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule